// File: doc/BRIEF.md
# Clock Output Power-Down Gating Controller

This block decides when the outputs of a multi-output clock generator stop and start. It also decides when the oscillator and PLL enables drop and return. One input pin serves two roles. After reset it reads as an active-low supply-good indication. Once that pin has been seen low, the same pin becomes an active-high power-down request.

The request is asynchronous. It is passed through a two-flop synchronizer and must then read high on two consecutive reference-clock edges before the block acts on it. Once the request is accepted:
- Each single-ended output freezes low at its own next falling edge.
- Each differential pair stops when its complement output falls. The pair then either parks (true driven high, complement released) or releases both outputs. A per-pair mode bit selects which.
- A deadline counter forces any pair that has not stopped within four reference cycles.
- The oscillator and PLL enables drop only when every output has stopped.

Release of the request is qualified in the same way. It brings the enables back and drives every stopped true output high. It then waits for PLL lock. After lock, the block turns the pairs back on one per cycle in index order, and turns all single-ended outputs on together in the cycle after the last pair. Output releases are modelled as separate output-enable signals. Every clock source is a level input sampled on the reference clock.

Top module: `clk_pd_gate`

## Requirements
- R1: After reset, status_o is 0 (boot), osc_en_o and pll_en_o are 1, every se_o bit and every diff_c_oe_o bit is 0. The first synchronized low on pd_pin_i moves status_o to 4 (relock).
- R2: A power-down request is taken only after pd_pin_i has read high on two consecutive edges after the two-flop synchronizer. A high pulse lasting one reference cycle leaves status_o at 1 (run).
- R3: While running, se_o equals se_src_i. Once status_o is 2 (halting), each se_o bit stays low from its first falling edge onward, and it stays low through status 3.
- R4: A stopped pair with drive_mode_i bit 0 has diff_t_o=1, diff_t_oe_o=1 and diff_c_oe_o=0. If not forced, it stops at the cycle in which its source rises, which is when the complement falls.
- R5: A stopped pair with drive_mode_i bit 1 has diff_t_oe_o=0 and diff_c_oe_o=0, except during status 4.
- R6: Every diff_c_oe_o bit is 0 no later than STOP_CYC (4) cycles after status_o first reads 2.
- R7: status_o becomes 3 (off) once every output is stopped. osc_en_o and pll_en_o are 0 exactly in status 3.
- R8: In status 3, two consecutive synchronized lows on pd_pin_i move status_o to 4 and raise osc_en_o and pll_en_o. In status 4, every stopped pair has diff_t_oe_o=1 and diff_t_o=1, whatever its mode bit.
- R9: In status 4 with pll_lock_i high, pair k turns on in the k-th cycle (k from 0). All se_o bits turn on in the next cycle, and status_o becomes 1.
- R10: While a pair runs, diff_t_o equals its source, diff_c_o is its inverse, and both output enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_pin_i | input | 1 | Dual-role pin: supply-good (low) at boot, then power-down request (high) |
| pll_lock_i | input | 1 | PLL lock indication |
| drive_mode_i | input | N_DIFF | Per-pair stop mode: 0 park high, 1 release both |
| se_src_i | input | N_SE | Single-ended source clock levels |
| diff_src_i | input | N_DIFF | Differential source clock levels (true phase) |
| se_o | output | N_SE | Gated single-ended outputs |
| diff_t_o | output | N_DIFF | True outputs of the pairs |
| diff_c_o | output | N_DIFF | Complement outputs of the pairs |
| diff_t_oe_o | output | N_DIFF | Drive enables of the true outputs |
| diff_c_oe_o | output | N_DIFF | Drive enables of the complement outputs |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| status_o | output | 3 | 0 boot, 1 run, 2 halting, 3 off, 4 relock |

## Verification
Free-running pair sources toggle every cycle at random phases. With them, the bench checks pass-through and a stop that is timed by the complement edge. Stuck pair sources never produce that edge, so they test the forced stop against the four-cycle deadline instead. Single-ended sources of different periods show that each output freezes at its own falling edge rather than all at one time. Random mode bits on every power-down cycle separate parking from release and show the drive-high override during relock. A one-cycle pin pulse and the staged restart after lock test the qualifier and the ordering.

// File: rtl/clk_pd_pkg.sv
`timescale 1ns/1ps
package clk_pd_pkg;
  typedef enum logic [2:0] {
    PD_ST_BOOT = 3'd0,
    PD_ST_RUN  = 3'd1,
    PD_ST_HALT = 3'd2,
    PD_ST_OFF  = 3'd3,
    PD_ST_LOCK = 3'd4
  } pd_state_e;
endpackage

// File: rtl/clk_pd_sync.sv
`timescale 1ns/1ps
module clk_pd_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) ff[s] <= {W{RST_VAL}};
    end else begin
      ff[0] <= d_i;
      for (int s = 1; s < STAGES; s++) ff[s] <= ff[s-1];
    end
  end

  assign q_o = ff[STAGES-1];
endmodule

// File: rtl/clk_pd_se_gate.sv
`timescale 1ns/1ps
module clk_pd_se_gate #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         stop_i,
  input  logic         en_i,
  output logic [N-1:0] se_o,
  output logic [N-1:0] live_o
);
  for (genvar k = 0; k < N; k++) begin : g_lane
    logic prev_q, live_q;
    logic fall;
    assign fall = prev_q & ~src_i[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        live_q <= 1'b0;
      end else begin
        prev_q <= src_i[k];
        if (en_i)              live_q <= 1'b1;
        else if (stop_i && fall) live_q <= 1'b0;
      end
    end

    // pass-through until the falling edge, then held low
    assign se_o[k]   = live_q & src_i[k];
    assign live_o[k] = live_q;
  end
endmodule

// File: rtl/clk_pd_diff_gate.sv
`timescale 1ns/1ps
module clk_pd_diff_gate #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] mode_i,
  input  logic         stop_i,
  input  logic         force_i,
  input  logic [N-1:0] en_i,
  input  logic         drive_hi_i,
  output logic [N-1:0] t_o,
  output logic [N-1:0] c_o,
  output logic [N-1:0] t_oe_o,
  output logic [N-1:0] c_oe_o
);
  for (genvar k = 0; k < N; k++) begin : g_pair
    logic prev_q, live_q;
    logic c_fall;
    // complement falls where the true phase rises
    assign c_fall = ~prev_q & src_i[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        live_q <= 1'b0;
      end else begin
        prev_q <= src_i[k];
        if (en_i[k])                                live_q <= 1'b1;
        else if (force_i || (stop_i && c_fall))     live_q <= 1'b0;
      end
    end

    assign t_o[k]    = live_q ? src_i[k] : 1'b1;
    assign c_o[k]    = live_q & ~src_i[k];
    assign t_oe_o[k] = live_q | ~mode_i[k] | drive_hi_i;
    assign c_oe_o[k] = live_q;
  end
endmodule

// File: rtl/clk_pd_seq.sv
`timescale 1ns/1ps
module clk_pd_seq
  import clk_pd_pkg::*;
#(
  parameter int N_DIFF   = 3,
  parameter int STOP_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_s_i,
  input  logic              pll_lock_i,
  input  logic              any_live_i,
  output pd_state_e         state_o,
  output logic              stop_o,
  output logic              force_o,
  output logic [N_DIFF-1:0] en_diff_o,
  output logic              en_se_o,
  output logic              drive_hi_o,
  output logic              osc_en_o,
  output logic              pll_en_o
);
  localparam int CW = $clog2(STOP_CYC + 1);
  localparam int SW = $clog2(N_DIFF + 1);

  pd_state_e state_q, state_d;
  logic          pin_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] stage_q;
  logic          req_on, req_off, step;

  assign req_on  = pin_s_i & pin_q;
  assign req_off = ~pin_s_i & ~pin_q;
  assign step    = (state_q == PD_ST_LOCK) & pll_lock_i & ~req_on;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PD_ST_BOOT: if (!pin_s_i) state_d = PD_ST_LOCK;
      PD_ST_LOCK: if (req_on) state_d = PD_ST_HALT;
                  else if (step && stage_q == SW'(N_DIFF)) state_d = PD_ST_RUN;
      PD_ST_RUN:  if (req_on) state_d = PD_ST_HALT;
      PD_ST_HALT: if (!any_live_i) state_d = PD_ST_OFF;
      PD_ST_OFF:  if (req_off) state_d = PD_ST_LOCK;
      default:    state_d = PD_ST_BOOT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PD_ST_BOOT;
      pin_q   <= 1'b1;
      cnt_q   <= '0;
      stage_q <= '0;
    end else begin
      state_q <= state_d;
      pin_q   <= pin_s_i;
      if (state_q != PD_ST_HALT)        cnt_q <= '0;
      else if (cnt_q != CW'(STOP_CYC))  cnt_q <= cnt_q + 1'b1;
      if (state_q != PD_ST_LOCK)        stage_q <= '0;
      else if (step)                    stage_q <= (stage_q == SW'(N_DIFF)) ? '0 : stage_q + 1'b1;
    end
  end

  for (genvar k = 0; k < N_DIFF; k++) begin : g_en
    assign en_diff_o[k] = step & (stage_q == SW'(k));
  end

  assign en_se_o    = step & (stage_q == SW'(N_DIFF));
  assign stop_o     = state_q == PD_ST_HALT;
  assign force_o    = stop_o & (cnt_q >= CW'(STOP_CYC - 1));
  assign drive_hi_o = state_q == PD_ST_LOCK;
  assign osc_en_o   = state_q != PD_ST_OFF;
  assign pll_en_o   = state_q != PD_ST_OFF;
  assign state_o    = state_q;
endmodule

// File: rtl/clk_pd_gate.sv
`timescale 1ns/1ps
module clk_pd_gate
  import clk_pd_pkg::*;
#(
  parameter int N_SE     = 4,
  parameter int N_DIFF   = 3,
  parameter int STOP_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_pin_i,
  input  logic              pll_lock_i,
  input  logic [N_DIFF-1:0] drive_mode_i,
  input  logic [N_SE-1:0]   se_src_i,
  input  logic [N_DIFF-1:0] diff_src_i,
  output logic [N_SE-1:0]   se_o,
  output logic [N_DIFF-1:0] diff_t_o,
  output logic [N_DIFF-1:0] diff_c_o,
  output logic [N_DIFF-1:0] diff_t_oe_o,
  output logic [N_DIFF-1:0] diff_c_oe_o,
  output logic              osc_en_o,
  output logic              pll_en_o,
  output logic [2:0]        status_o
);
  logic              pin_s;
  logic              stop, force_stop, en_se, drive_hi;
  logic [N_DIFF-1:0] en_diff;
  logic [N_SE-1:0]   se_live;
  pd_state_e         state;

  clk_pd_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) i_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pd_pin_i),
    .q_o   (pin_s)
  );

  clk_pd_seq #(.N_DIFF(N_DIFF), .STOP_CYC(STOP_CYC)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_s_i   (pin_s),
    .pll_lock_i(pll_lock_i),
    .any_live_i((|se_live) | (|diff_c_oe_o)),
    .state_o   (state),
    .stop_o    (stop),
    .force_o   (force_stop),
    .en_diff_o (en_diff),
    .en_se_o   (en_se),
    .drive_hi_o(drive_hi),
    .osc_en_o  (osc_en_o),
    .pll_en_o  (pll_en_o)
  );

  clk_pd_se_gate #(.N(N_SE)) i_se (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (se_src_i),
    .stop_i(stop),
    .en_i  (en_se),
    .se_o  (se_o),
    .live_o(se_live)
  );

  clk_pd_diff_gate #(.N(N_DIFF)) i_diff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (diff_src_i),
    .mode_i    (drive_mode_i),
    .stop_i    (stop),
    .force_i   (force_stop),
    .en_i      (en_diff),
    .drive_hi_i(drive_hi),
    .t_o       (diff_t_o),
    .c_o       (diff_c_o),
    .t_oe_o    (diff_t_oe_o),
    .c_oe_o    (diff_c_oe_o)
  );

  assign status_o = state;
endmodule

// File: rtl/clk_pd_gate_chk.sv
`timescale 1ns/1ps
module clk_pd_gate_chk
  import clk_pd_pkg::*;
#(
  parameter int N_SE     = 4,
  parameter int N_DIFF   = 3,
  parameter int STOP_CYC = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_DIFF-1:0] drive_mode_i,
  input logic [N_SE-1:0]   se_o,
  input logic [N_DIFF-1:0] diff_t_o,
  input logic [N_DIFF-1:0] diff_t_oe_o,
  input logic [N_DIFF-1:0] diff_c_oe_o,
  input logic              osc_en_o,
  input logic              pll_en_o,
  input logic [2:0]        status_o
);
  localparam int CW = $clog2(STOP_CYC + 2);
  logic [CW-1:0] halt_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        halt_cnt <= '0;
    else if (status_o != PD_ST_HALT)    halt_cnt <= '0;
    else if (halt_cnt != CW'(STOP_CYC + 1)) halt_cnt <= halt_cnt + 1'b1;
  end

  assert_enables_after_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (se_o == '0 && diff_c_oe_o == '0));

  assert_enables_track_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_o == pll_en_o) && (osc_en_o == (status_o != PD_ST_OFF)));

  assert_park_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~diff_c_oe_o & ~drive_mode_i) & ~(diff_t_oe_o & diff_t_o)) == '0);

  assert_release_both_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != PD_ST_LOCK) |-> ((drive_mode_i & ~diff_c_oe_o & diff_t_oe_o) == '0));

  assert_relock_drive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == PD_ST_LOCK) |-> ((~diff_c_oe_o & ~(diff_t_oe_o & diff_t_o)) == '0));

  assert_stop_deadline_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == PD_ST_HALT && halt_cnt >= CW'(STOP_CYC)) |-> diff_c_oe_o == '0);

  assert_one_pair_per_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(diff_c_oe_o & ~$past(diff_c_oe_o)) <= 1);

  assert_off_held_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == PD_ST_OFF) |-> se_o == '0);
endmodule

bind clk_pd_gate clk_pd_gate_chk #(.N_SE(N_SE), .N_DIFF(N_DIFF), .STOP_CYC(STOP_CYC)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .drive_mode_i(drive_mode_i),
  .se_o        (se_o),
  .diff_t_o    (diff_t_o),
  .diff_t_oe_o (diff_t_oe_o),
  .diff_c_oe_o (diff_c_oe_o),
  .osc_en_o    (osc_en_o),
  .pll_en_o    (pll_en_o),
  .status_o    (status_o)
);

// File: tb/test_clk_pd_gate.sv
`timescale 1ns/1ps
module test_clk_pd_gate;
  localparam int N_SE = 4, N_DIFF = 3, STOP_CYC = 4;
  localparam logic [2:0] S_BOOT = 3'd0, S_RUN = 3'd1, S_HALT = 3'd2, S_OFF = 3'd3, S_LOCK = 3'd4;
  localparam logic [N_DIFF-1:0] ALL_D = '1;

  logic clk = 1'b0, rst_n = 1'b0, pin = 1'b1, lock = 1'b0;
  logic [N_DIFF-1:0] mode = '0, dsrc = '0;
  logic [N_SE-1:0]   ssrc = '0;
  logic [N_SE-1:0]   se_o;
  logic [N_DIFF-1:0] t_o, c_o, t_oe, c_oe;
  logic osc_en, pll_en;
  logic [2:0] status;

  int  n_chk = 0, n_fail = 0, tick_n = 0;
  bit  dstuck = 1'b0, done = 1'b0;

  clk_pd_gate #(.N_SE(N_SE), .N_DIFF(N_DIFF), .STOP_CYC(STOP_CYC)) i_clk_pd_gate (
    .clk_i(clk), .rst_ni(rst_n), .pd_pin_i(pin), .pll_lock_i(lock),
    .drive_mode_i(mode), .se_src_i(ssrc), .diff_src_i(dsrc),
    .se_o(se_o), .diff_t_o(t_o), .diff_c_o(c_o), .diff_t_oe_o(t_oe), .diff_c_oe_o(c_oe),
    .osc_en_o(osc_en), .pll_en_o(pll_en), .status_o(status)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive 1 ns after the rising edge, return at the falling edge for sampling
  task automatic tick();
    @(posedge clk);
    #1;
    tick_n++;
    if (!dstuck) dsrc = ~dsrc;
    for (int i = 0; i < N_SE; i++)
      if (tick_n % (i + 2) == 0) ssrc[i] = ~ssrc[i];
    #1;
  endtask

  task automatic wait_status(logic [2:0] tgt, int max, string req);
    int n = 0;
    while (status != tgt && n < max) begin tick(); n++; end
    chk(req, "status reached", {29'd0, status}, {29'd0, tgt});
  endtask

  function automatic logic [N_DIFF-1:0] prefix(int k);
    return N_DIFF'((1 << k) - 1);
  endfunction

  function automatic logic [N_DIFF-1:0] exp_stop_toe(logic [N_DIFF-1:0] m, bit relock);
    return relock ? ALL_D : ~m;
  endfunction

  task automatic restart();
    lock = 1'b1;
    for (int k = 0; k < N_DIFF; k++) begin
      tick();
      chk("R9", "pair staging", {29'd0, c_oe}, {29'd0, prefix(k + 1)});
      chk("R9", "single-ended held during staging", {28'd0, se_o}, 32'd0);
    end
    tick();
    chk("R9", "run after last stage", {29'd0, status}, {29'd0, S_RUN});
    chk("R3", "single-ended follow source", {28'd0, se_o}, {28'd0, ssrc});
  endtask

  task automatic run_check(int n);
    for (int i = 0; i < n; i++) begin
      tick();
      chk("R10", "true follows source", {29'd0, t_o}, {29'd0, dsrc});
      chk("R10", "complement inverted", {29'd0, c_o}, {29'd0, ~dsrc});
      chk("R10", "both enables on", {26'd0, t_oe, c_oe}, {26'd0, ALL_D, ALL_D});
      chk("R3", "single-ended follow source", {28'd0, se_o}, {28'd0, ssrc});
    end
  endtask

  task automatic power_cycle(int it);
    logic [N_SE-1:0] prev_se, fell;
    int n;
    mode   = N_DIFF'($urandom);
    dstuck = (it % 3 == 2);
    run_check(2 + ($urandom % 4));
    pin = 1'b1;
    wait_status(S_HALT, 8, "R2");
    prev_se = se_o;
    fell    = '0;
    n = 0;
    while (c_oe != '0 && n < 20) begin
      tick(); n++;
      for (int i = 0; i < N_SE; i++) begin
        if (fell[i] && se_o[i]) begin
          n_fail++; $display("FAIL R3 se lane %0d rose after stop actual=1 expected=0", i);
        end
        if (prev_se[i] && !se_o[i]) fell[i] = 1'b1;
      end
      prev_se = se_o;
    end
    n_chk++;
    if (n > STOP_CYC) begin
      n_fail++; $display("FAIL R6 pair stop cycles actual=%0d expected<=%0d", n, STOP_CYC);
    end
    if (status != S_OFF)
      chk("R7", "enables kept while halting", {30'd0, osc_en, pll_en}, 32'd3);
    n = 0;
    while (status != S_OFF && n < 40) begin
      tick(); n++;
      for (int i = 0; i < N_SE; i++) begin
        if (fell[i] && se_o[i]) begin
          n_fail++; $display("FAIL R3 se lane %0d rose after stop actual=1 expected=0", i);
        end
        if (prev_se[i] && !se_o[i]) fell[i] = 1'b1;
      end
      prev_se = se_o;
    end
    chk("R7", "off reached", {29'd0, status}, {29'd0, S_OFF});
    chk("R7", "enables dropped", {30'd0, osc_en, pll_en}, 32'd0);
    chk("R4", "parked true level", {29'd0, t_o | mode}, {29'd0, ALL_D});
    chk("R5", "true enable per mode", {29'd0, t_oe}, {29'd0, exp_stop_toe(mode, 1'b0)});
    lock = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R3", "held low while off", {28'd0, se_o}, 32'd0);
    end
    pin = 1'b0;
    wait_status(S_LOCK, 8, "R8");
    chk("R8", "enables restored", {30'd0, osc_en, pll_en}, 32'd3);
    chk("R8", "true driven high", {26'd0, t_oe, t_o}, {26'd0, exp_stop_toe(mode, 1'b1), ALL_D});
    chk("R8", "complement released", {29'd0, c_oe}, 32'd0);
    for (int i = 0; i < int'($urandom % 5); i++) tick();
    dstuck = 1'b0;
    restart();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    dsrc = N_DIFF'($urandom);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1", "boot status", {29'd0, status}, {29'd0, S_BOOT});
    chk("R1", "boot outputs", {25'd0, se_o, c_oe}, 32'd0);
    chk("R1", "boot enables", {30'd0, osc_en, pll_en}, 32'd3);
    pin = 1'b0;
    wait_status(S_LOCK, 6, "R1");
    repeat (5) tick();
    chk("R8", "waiting for lock, true high", {26'd0, t_oe, t_o}, {26'd0, ALL_D, ALL_D});
    chk("R1", "no output before lock", {25'd0, se_o, c_oe}, 32'd0);
    restart();
    run_check(20);
    // single-cycle pulse must be rejected
    pin = 1'b1; tick(); pin = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R2", "short pulse ignored", {29'd0, status}, {29'd0, S_RUN});
    end
    for (int it = 0; it < 12; it++) power_cycle(it);
    run_check(10);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", tick_n);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule